// File: doc/BRIEF.md
# Accumulator Arithmetic and Flag Unit

This block performs the data operations of a small 8-bit accumulator processor. Each operation takes the accumulator, an optional second operand and the current flag byte, and returns a result byte, a new flag byte and a strobe that says whether the result should be written back to the accumulator. A one-bit group select chooses between two sets of eight operations. The first set is the two-operand arithmetic and logic set. The second set works on the accumulator alone: rotates, decimal adjust, complement, and carry set or toggle. Operand fetch, memory-indirect addressing and decode all happen upstream. The caller forms the 3-bit operation code from bits 5:3 of the instruction.

The arithmetic is purely combinational, split between a two-operand datapath and an accumulator datapath, with a selector that merges them. A wrapper registers the selected outputs once per accepted request. When `in_valid` is high on a clock edge, the result, flags and write strobe for that request appear right after the edge, and `out_valid` rises for that one cycle. When `in_valid` is low, the registered outputs keep their values. The wrapper has only two named conditions: IDLE, where `out_valid` is low and the outputs hold, and LOADED, the cycle after an accepted request. The transition IDLE→LOADED or LOADED→LOADED happens on any edge with `in_valid` high. The transition back to IDLE happens on any edge with `in_valid` low.

Top module: `acc_alu_unit`

## Requirements
- R1: The flag byte has zero at bit 7, subtract at bit 6, half-carry at bit 5 and carry at bit 4. Bits 3:0 of `flags_out` are always 0, whatever `flags_in[3:0]` holds.
- R2: Group 0 (`grp_acc`=0) with code 000 adds `opnd_in` to `acc_in`, and code 001 also adds the incoming carry (`flags_in[4]`). Half-carry is the carry out of bit 3, carry is the carry out of bit 7, subtract is cleared and zero reflects the 8-bit result. Code 000 ignores the incoming carry.
- R3: Group 0 with code 010 subtracts, and code 011 also subtracts the incoming carry. Half-carry is the borrow from bit 4, carry is the borrow from bit 8, subtract is set and zero reflects the result.
- R4: Group 0 with code 111 (compare) produces the flags and result byte of code 010, but `res_we` is 0.
- R5: Group 0 with code 100 gives AND with half-carry set. Code 101 gives XOR and code 110 gives OR, both with half-carry clear. All three clear subtract and carry, and set zero when the result is 0.
- R6: Group 1 codes 000, 001, 010 and 011 rotate the accumulator left around, right around, left through carry and right through carry. Carry takes the bit shifted out, and zero, subtract and half-carry are cleared.
- R7: Group 1 code 100 is a decimal adjust. When subtract is clear, it adds 0x60 if carry is set or the accumulator exceeds 0x99, and adds 0x06 if half-carry is set or the low nibble exceeds 9. When subtract is set, it subtracts 0x60 if carry is set and 0x06 if half-carry is set. Carry becomes 1 exactly when the 0x60 step applies, half-carry is cleared, subtract is unchanged and zero reflects the result.
- R8: Group 1 code 101 complements the accumulator and sets subtract and half-carry. Code 110 sets carry, and code 111 inverts carry; both clear subtract and half-carry and return the accumulator unchanged. All three leave zero and, for 101, carry unchanged.
- R9: `res_we` is 1 for every operation except group 0 code 111.
- R10: After a clock edge with `in_valid` high, `res_out`, `flags_out` and `res_we` show that request's values and `out_valid` is 1. After an edge with `in_valid` low, `out_valid` is 0 and the other outputs keep their values.
- R11: While `rst_n` is low, all outputs are 0 regardless of the inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| grp_acc | input | 1 | 0 = two-operand group, 1 = accumulator group |
| op_code | input | 3 | Operation within the selected group |
| acc_in | input | 8 | Accumulator value |
| opnd_in | input | 8 | Second operand (group 0 only) |
| flags_in | input | 8 | Current flag byte |
| out_valid | output | 1 | Outputs hold a fresh result |
| res_out | output | 8 | Result byte |
| flags_out | output | 8 | New flag byte |
| res_we | output | 1 | Write the result back to the accumulator |

## Verification
The hardest case to reach is decimal adjust with a flag byte that only a subtraction could have left behind, such as subtract and half-carry set with carry clear. In a processor this needs a specific subtraction immediately before the adjust. Here the flag byte is a direct input, so the bench drives all eight subtract/half-carry/carry combinations for every accumulator value. Carry and half-carry boundaries of add and subtract are reached by sweeping every operand pair, with both values of the incoming carry, through a second instance of the combinational core.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
    localparam int DW = 8;
    localparam int NW = DW / 2;

    localparam int FLG_Z = 7;
    localparam int FLG_N = 6;
    localparam int FLG_H = 5;
    localparam int FLG_C = 4;

    typedef enum logic [2:0] {
        TOP_ADD = 3'd0,
        TOP_ADC = 3'd1,
        TOP_SUB = 3'd2,
        TOP_SBC = 3'd3,
        TOP_AND = 3'd4,
        TOP_XOR = 3'd5,
        TOP_OR  = 3'd6,
        TOP_CMP = 3'd7
    } two_op_e;

    typedef enum logic [2:0] {
        AOP_ROLC = 3'd0,
        AOP_RORC = 3'd1,
        AOP_ROLT = 3'd2,
        AOP_RORT = 3'd3,
        AOP_DADJ = 3'd4,
        AOP_CPL  = 3'd5,
        AOP_SCF  = 3'd6,
        AOP_CCF  = 3'd7
    } acc_op_e;

    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } flag_t;
endpackage

// File: rtl/acc_alu_twoop.sv
module acc_alu_twoop
    import acc_alu_pkg::*;
(
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic          cin_i,
    input  two_op_e       op_i,
    output logic [DW-1:0] res_o,
    output flag_t         flg_o,
    output logic          we_o
);
    logic          cuse;
    logic [DW:0]   sum_w;
    logic [DW:0]   dif_w;
    logic [NW:0]   hsum_w;
    logic [NW:0]   hdif_w;

    // carry-in only for the two "with carry" codes
    always_comb begin
        cuse   = (op_i == TOP_ADC || op_i == TOP_SBC) ? cin_i : 1'b0;
        sum_w  = {1'b0, a_i} + {1'b0, b_i} + {{DW{1'b0}}, cuse};
        dif_w  = {1'b0, a_i} - {1'b0, b_i} - {{DW{1'b0}}, cuse};
        hsum_w = {1'b0, a_i[NW-1:0]} + {1'b0, b_i[NW-1:0]} + {{NW{1'b0}}, cuse};
        hdif_w = {1'b0, a_i[NW-1:0]} - {1'b0, b_i[NW-1:0]} - {{NW{1'b0}}, cuse};
    end

    always_comb begin
        res_o = '0;
        flg_o = '0;
        we_o  = 1'b1;
        unique case (op_i)
            TOP_ADD, TOP_ADC: begin
                res_o   = sum_w[DW-1:0];
                flg_o.h = hsum_w[NW];
                flg_o.c = sum_w[DW];
            end
            TOP_SUB, TOP_SBC, TOP_CMP: begin
                res_o   = dif_w[DW-1:0];
                flg_o.n = 1'b1;
                flg_o.h = hdif_w[NW];
                flg_o.c = dif_w[DW];
                we_o    = (op_i != TOP_CMP);
            end
            TOP_AND: begin
                res_o   = a_i & b_i;
                flg_o.h = 1'b1;
            end
            TOP_XOR: res_o = a_i ^ b_i;
            TOP_OR:  res_o = a_i | b_i;
            default: res_o = '0;
        endcase
        flg_o.z = (res_o == '0);
    end
endmodule

// File: rtl/acc_alu_accop.sv
module acc_alu_accop
    import acc_alu_pkg::*;
(
    input  logic [DW-1:0] a_i,
    input  flag_t         flg_i,
    input  acc_op_e       op_i,
    output logic [DW-1:0] res_o,
    output flag_t         flg_o
);
    logic          lo_fix;
    logic          hi_fix;
    logic [DW-1:0] adj_w;
    logic [DW-1:0] dadj_w;

    // decimal correction: direction from subtract flag
    always_comb begin
        if (flg_i.n) begin
            lo_fix = flg_i.h;
            hi_fix = flg_i.c;
        end else begin
            lo_fix = flg_i.h || (a_i[NW-1:0] > NW'(9));
            hi_fix = flg_i.c || (a_i > DW'(8'h99));
        end
        adj_w  = {(hi_fix ? NW'(6) : NW'(0)), (lo_fix ? NW'(6) : NW'(0))};
        dadj_w = flg_i.n ? (a_i - adj_w) : (a_i + adj_w);
    end

    always_comb begin
        res_o = a_i;
        flg_o = flg_i;
        unique case (op_i)
            AOP_ROLC: begin
                res_o = {a_i[DW-2:0], a_i[DW-1]};
                flg_o = '{z: 1'b0, n: 1'b0, h: 1'b0, c: a_i[DW-1]};
            end
            AOP_RORC: begin
                res_o = {a_i[0], a_i[DW-1:1]};
                flg_o = '{z: 1'b0, n: 1'b0, h: 1'b0, c: a_i[0]};
            end
            AOP_ROLT: begin
                res_o = {a_i[DW-2:0], flg_i.c};
                flg_o = '{z: 1'b0, n: 1'b0, h: 1'b0, c: a_i[DW-1]};
            end
            AOP_RORT: begin
                res_o = {flg_i.c, a_i[DW-1:1]};
                flg_o = '{z: 1'b0, n: 1'b0, h: 1'b0, c: a_i[0]};
            end
            AOP_DADJ: begin
                res_o = dadj_w;
                flg_o = '{z: (dadj_w == '0), n: flg_i.n, h: 1'b0, c: hi_fix};
            end
            AOP_CPL: begin
                res_o   = ~a_i;
                flg_o.n = 1'b1;
                flg_o.h = 1'b1;
            end
            AOP_SCF: begin
                flg_o.n = 1'b0;
                flg_o.h = 1'b0;
                flg_o.c = 1'b1;
            end
            AOP_CCF: begin
                flg_o.n = 1'b0;
                flg_o.h = 1'b0;
                flg_o.c = ~flg_i.c;
            end
            default: res_o = a_i;
        endcase
    end
endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
    import acc_alu_pkg::*;
(
    input  logic          grp_acc_i,
    input  logic [2:0]    op_i,
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic [DW-1:0] flags_i,
    output logic [DW-1:0] res_o,
    output logic [DW-1:0] flags_o,
    output logic          we_o
);
    flag_t         fin;
    logic [DW-1:0] two_res;
    flag_t         two_flg;
    logic          two_we;
    logic [DW-1:0] acc_res;
    flag_t         acc_flg;
    logic          unused_lo;

    assign fin       = flag_t'(flags_i[DW-1:NW]);
    assign unused_lo = ^flags_i[NW-1:0];

    acc_alu_twoop u_twoop (
        .a_i   (a_i),
        .b_i   (b_i),
        .cin_i (fin.c),
        .op_i  (two_op_e'(op_i)),
        .res_o (two_res),
        .flg_o (two_flg),
        .we_o  (two_we)
    );

    acc_alu_accop u_accop (
        .a_i   (a_i),
        .flg_i (fin),
        .op_i  (acc_op_e'(op_i)),
        .res_o (acc_res),
        .flg_o (acc_flg)
    );

    always_comb begin
        if (grp_acc_i) begin
            res_o   = acc_res;
            flags_o = {acc_flg, {NW{1'b0}}};
            we_o    = 1'b1;
        end else begin
            res_o   = two_res;
            flags_o = {two_flg, {NW{1'b0}}};
            we_o    = two_we;
        end
    end
endmodule

// File: rtl/acc_alu_unit.sv
module acc_alu_unit
    import acc_alu_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          grp_acc,
    input  logic [2:0]    op_code,
    input  logic [DW-1:0] acc_in,
    input  logic [DW-1:0] opnd_in,
    input  logic [DW-1:0] flags_in,
    output logic          out_valid,
    output logic [DW-1:0] res_out,
    output logic [DW-1:0] flags_out,
    output logic          res_we
);
    logic [DW-1:0] core_res;
    logic [DW-1:0] core_flags;
    logic          core_we;

    logic [DW-1:0] res_nxt;
    logic [DW-1:0] flags_nxt;
    logic          we_nxt;

    acc_alu_core u_core (
        .grp_acc_i (grp_acc),
        .op_i      (op_code),
        .a_i       (acc_in),
        .b_i       (opnd_in),
        .flags_i   (flags_in),
        .res_o     (core_res),
        .flags_o   (core_flags),
        .we_o      (core_we)
    );

    // next-value selection: load on request, hold otherwise
    always_comb begin
        if (in_valid) begin
            res_nxt   = core_res;
            flags_nxt = core_flags;
            we_nxt    = core_we;
        end else begin
            res_nxt   = res_out;
            flags_nxt = flags_out;
            we_nxt    = res_we;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            res_out   <= '0;
            flags_out <= '0;
            res_we    <= 1'b0;
        end else begin
            out_valid <= in_valid;
            res_out   <= res_nxt;
            flags_out <= flags_nxt;
            res_we    <= we_nxt;
        end
    end

    // R4: compare never requests write-back
    p_cmp_no_we_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !grp_acc && op_code == 3'd7) |=> !res_we);

    // R10: valid follows an accepted request
    p_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R10: idle cycles hold outputs
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(res_out) && $stable(flags_out) && $stable(res_we)));

    // R6: rotates clear zero, subtract, half-carry
    p_rot_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && grp_acc && !op_code[2]) |=> (flags_out[FLG_Z:FLG_H] == 3'b000));

    // R8: set-carry result
    p_scf_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && grp_acc && op_code == 3'd6) |=>
        (flags_out[FLG_C] && !flags_out[FLG_N] && !flags_out[FLG_H]));

    // R8: complement and carry ops keep zero
    p_keep_z_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && grp_acc && op_code >= 3'd5) |=> (flags_out[FLG_Z] == $past(flags_in[FLG_Z])));
endmodule

// File: tb/acc_alu_unit_bench.sv
`timescale 1ns/1ps
module acc_alu_unit_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       grp_acc = 1'b0;
    logic [2:0] op_code = 3'd0;
    logic [7:0] acc_in = 8'h00;
    logic [7:0] opnd_in = 8'h00;
    logic [7:0] flags_in = 8'h00;
    logic       out_valid;
    logic [7:0] res_out;
    logic [7:0] flags_out;
    logic       res_we;

    logic       x_grp = 1'b0;
    logic [2:0] x_op = 3'd0;
    logic [7:0] x_a = 8'h00;
    logic [7:0] x_b = 8'h00;
    logic [7:0] x_f = 8'h00;
    logic [7:0] x_res;
    logic [7:0] x_flags;
    logic       x_we;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    acc_alu_unit u_acc_alu_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .grp_acc   (grp_acc),
        .op_code   (op_code),
        .acc_in    (acc_in),
        .opnd_in   (opnd_in),
        .flags_in  (flags_in),
        .out_valid (out_valid),
        .res_out   (res_out),
        .flags_out (flags_out),
        .res_we    (res_we)
    );

    acc_alu_core u_core_exh (
        .grp_acc_i (x_grp),
        .op_i      (x_op),
        .a_i       (x_a),
        .b_i       (x_b),
        .flags_i   (x_f),
        .res_o     (x_res),
        .flags_o   (x_flags),
        .we_o      (x_we)
    );

    // {req, grp, op, a, b, flags_in, exp_res, exp_flags, exp_we}
    localparam int NV = 24;
    localparam logic [48:0] VEC [NV] = '{
        {4'd2, 1'b0, 3'd0, 8'h3A, 8'hC6, 8'h00, 8'h00, 8'hB0, 1'b1}, // R2 add wraps to zero
        {4'd2, 1'b0, 3'd1, 8'hE1, 8'h0F, 8'h10, 8'hF1, 8'h20, 1'b1}, // R2 add with carry
        {4'd2, 1'b0, 3'd0, 8'h01, 8'h01, 8'h10, 8'h02, 8'h00, 1'b1}, // R2 plain add ignores carry
        {4'd3, 1'b0, 3'd2, 8'h3E, 8'h3E, 8'h00, 8'h00, 8'hC0, 1'b1}, // R3 equal subtract
        {4'd3, 1'b0, 3'd2, 8'h3E, 8'h40, 8'h00, 8'hFE, 8'h50, 1'b1}, // R3 borrow out
        {4'd3, 1'b0, 3'd3, 8'h3B, 8'h2A, 8'h10, 8'h10, 8'h40, 1'b1}, // R3 subtract with carry
        {4'd4, 1'b0, 3'd7, 8'h3C, 8'h2F, 8'h00, 8'h0D, 8'h60, 1'b0}, // R4 compare half-borrow
        {4'd4, 1'b0, 3'd7, 8'h42, 8'h42, 8'h00, 8'h00, 8'hC0, 1'b0}, // R4 compare equal
        {4'd5, 1'b0, 3'd4, 8'h5A, 8'h3F, 8'h00, 8'h1A, 8'h20, 1'b1}, // R5 AND
        {4'd5, 1'b0, 3'd5, 8'hFF, 8'hFF, 8'hF0, 8'h00, 8'h80, 1'b1}, // R5 XOR to zero
        {4'd5, 1'b0, 3'd6, 8'h00, 8'h00, 8'h00, 8'h00, 8'h80, 1'b1}, // R5 OR zero
        {4'd5, 1'b0, 3'd6, 8'h50, 8'h0A, 8'h30, 8'h5A, 8'h00, 1'b1}, // R5 OR clears carry
        {4'd6, 1'b1, 3'd0, 8'h85, 8'h00, 8'hE0, 8'h0B, 8'h10, 1'b1}, // R6 rotate left around
        {4'd6, 1'b1, 3'd2, 8'h95, 8'h00, 8'h10, 8'h2B, 8'h10, 1'b1}, // R6 rotate left through
        {4'd6, 1'b1, 3'd1, 8'h3B, 8'h00, 8'h00, 8'h9D, 8'h10, 1'b1}, // R6 rotate right around
        {4'd6, 1'b1, 3'd3, 8'h81, 8'h00, 8'h00, 8'h40, 8'h10, 1'b1}, // R6 rotate right through
        {4'd6, 1'b1, 3'd3, 8'h01, 8'h00, 8'h10, 8'h80, 8'h10, 1'b1}, // R6 carry into bit 7
        {4'd7, 1'b1, 3'd4, 8'h7D, 8'h00, 8'h00, 8'h83, 8'h00, 1'b1}, // R7 low correction
        {4'd7, 1'b1, 3'd4, 8'h4B, 8'h00, 8'h60, 8'h45, 8'h40, 1'b1}, // R7 after subtract
        {4'd7, 1'b1, 3'd4, 8'h9A, 8'h00, 8'h00, 8'h00, 8'h90, 1'b1}, // R7 both corrections
        {4'd8, 1'b1, 3'd5, 8'h35, 8'h00, 8'h90, 8'hCA, 8'hF0, 1'b1}, // R8 complement
        {4'd8, 1'b1, 3'd6, 8'h12, 8'h00, 8'hE0, 8'h12, 8'h90, 1'b1}, // R8 set carry
        {4'd8, 1'b1, 3'd7, 8'h12, 8'h00, 8'h70, 8'h12, 8'h00, 1'b1}, // R8 toggle carry off
        {4'd1, 1'b0, 3'd0, 8'h01, 8'h01, 8'h0F, 8'h02, 8'h00, 1'b1}  // R1 low nibble ignored
    };

    function automatic logic [16:0] ref_alu(input logic grp, input logic [2:0] op,
                                            input logic [7:0] a, input logic [7:0] b,
                                            input logic [7:0] f);
        int ai, bi, ci, r;
        logic z, n, h, c, we;
        ai = int'(a); bi = int'(b); ci = int'(f[4]);
        z = f[7]; n = f[6]; h = f[5]; c = f[4];
        we = 1'b1; r = ai;
        if (!grp) begin
            case (op)
                3'd0: begin r = ai + bi; h = ((ai % 16) + (bi % 16)) > 15; c = r > 255; n = 1'b0; end
                3'd1: begin r = ai + bi + ci; h = ((ai % 16) + (bi % 16) + ci) > 15; c = r > 255; n = 1'b0; end
                3'd2, 3'd7: begin
                    r = ai - bi; h = (ai % 16) < (bi % 16); c = ai < bi; n = 1'b1;
                    we = (op != 3'd7);
                end
                3'd3: begin r = ai - bi - ci; h = (ai % 16) < ((bi % 16) + ci); c = ai < (bi + ci); n = 1'b1; end
                3'd4: begin r = ai & bi; n = 1'b0; h = 1'b1; c = 1'b0; end
                3'd5: begin r = ai ^ bi; n = 1'b0; h = 1'b0; c = 1'b0; end
                default: begin r = ai | bi; n = 1'b0; h = 1'b0; c = 1'b0; end
            endcase
            r = r & 255;
            z = (r == 0);
        end else begin
            case (op)
                3'd0: begin r = ((ai * 2) % 256) + ai / 128; c = a[7]; z = 0; n = 0; h = 0; end
                3'd1: begin r = ai / 2 + (ai % 2) * 128; c = a[0]; z = 0; n = 0; h = 0; end
                3'd2: begin r = ((ai * 2) % 256) + ci; c = a[7]; z = 0; n = 0; h = 0; end
                3'd3: begin r = ai / 2 + ci * 128; c = a[0]; z = 0; n = 0; h = 0; end
                3'd4: begin
                    if (!n) begin
                        if (c || ai > 153) begin r = r + 96; c = 1'b1; end
                        if (h || (ai % 16) > 9) r = r + 6;
                    end else begin
                        if (c) r = r - 96;
                        if (h) r = r - 6;
                    end
                    r = r & 255;
                    h = 1'b0;
                    z = (r == 0);
                end
                3'd5: begin r = 255 - ai; n = 1'b1; h = 1'b1; end
                3'd6: begin n = 1'b0; h = 1'b0; c = 1'b1; end
                default: begin n = 1'b0; h = 1'b0; c = ~c; end
            endcase
        end
        return {we, z, n, h, c, 4'b0000, r[7:0]};
    endfunction

    task automatic check(input string tag, input logic [7:0] ar, input logic [7:0] er,
                         input logic [7:0] af, input logic [7:0] ef,
                         input logic aw, input logic ew);
        checks++;
        if (ar !== er || af !== ef || aw !== ew) begin
            errors++;
            $display("FAIL %s: res=%h flags=%h we=%b, expected res=%h flags=%h we=%b",
                     tag, ar, af, aw, er, ef, ew);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [16:0] exp;
        // R11: reset holds outputs at zero even with a request present
        @(negedge clk);
        in_valid = 1'b1; grp_acc = 1'b1; op_code = 3'd5; acc_in = 8'h35; flags_in = 8'h00;
        @(negedge clk);
        check("R11 reset", res_out, 8'h00, flags_out, 8'h00, res_we, 1'b0);
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R11 out_valid: got %b, expected 0", out_valid);
        end
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk, one request per edge
        for (int i = 0; i < NV; i++) begin
            {grp_acc, op_code, acc_in, opnd_in, flags_in} = VEC[i][44:17];
            in_valid = 1'b1;
            @(negedge clk);
            // R9: write strobe column; R10: fresh result after one edge
            check($sformatf("R%0d vector %0d", VEC[i][48:45], i),
                  res_out, VEC[i][16:9], flags_out, VEC[i][8:1], res_we, VEC[i][0]);
            checks++;
            if (out_valid !== 1'b1) begin
                errors++;
                $display("FAIL R10 out_valid vector %0d: got %b, expected 1", i, out_valid);
            end
        end

        // R10: idle edge keeps last outputs although inputs change
        in_valid = 1'b0; grp_acc = 1'b0; op_code = 3'd0; acc_in = 8'hFF; opnd_in = 8'hFF;
        flags_in = 8'h00;
        @(negedge clk);
        check("R10 hold", res_out, 8'h02, flags_out, 8'h00, res_we, 1'b1);
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R10 idle out_valid: got %b, expected 0", out_valid);
        end

        // R9/R4: compare then subtract, strobe toggles back
        in_valid = 1'b1; op_code = 3'd7; acc_in = 8'h10; opnd_in = 8'h20;
        @(negedge clk);
        check("R4 compare borrow", res_out, 8'hF0, flags_out, 8'h50, res_we, 1'b0);
        op_code = 3'd2;
        @(negedge clk);
        check("R9 subtract strobe", res_out, 8'hF0, flags_out, 8'h50, res_we, 1'b1);
        in_valid = 1'b0;
        @(negedge clk);

        // R2 R3: every operand pair for add/subtract codes
        x_grp = 1'b0;
        for (int op = 0; op < 4; op++) begin
            for (int cin = 0; cin < 2; cin++) begin
                if (cin == 1 && (op == 0 || op == 2)) continue;
                for (int a = 0; a < 256; a++) begin
                    for (int b = 0; b < 256; b++) begin
                        x_op = 3'(op); x_a = 8'(a); x_b = 8'(b); x_f = cin ? 8'h10 : 8'h00;
                        #1;
                        exp = ref_alu(x_grp, x_op, x_a, x_b, x_f);
                        check($sformatf("%s sweep op=%0d a=%h b=%h cin=%0d",
                                        (op < 2) ? "R2" : "R3", op, a, b, cin),
                              x_res, exp[7:0], x_flags, exp[15:8], x_we, exp[16]);
                    end
                end
            end
        end

        // R7: every accumulator with every subtract/half/carry combination
        x_grp = 1'b1; x_op = 3'd4; x_b = 8'h00;
        for (int a = 0; a < 256; a++) begin
            for (int fl = 0; fl < 8; fl++) begin
                x_a = 8'(a); x_f = {1'b0, 3'(fl), 4'b0000};
                #1;
                exp = ref_alu(x_grp, x_op, x_a, x_b, x_f);
                check($sformatf("R7 adjust sweep a=%h nhc=%0d", a, fl),
                      x_res, exp[7:0], x_flags, exp[15:8], x_we, exp[16]);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule